// File: doc/BRIEF.md
# Overlay Window Tracker

This block places a rectangular overlay window inside a video raster. Every pixel clock it compares the master raster column and line counters against four programmable edges: left, right, top and bottom. From these compares it keeps one sticky "outside" flag per axis. No adder or subtractor ever touches the raster counters. Two local counters give the pixel position inside the window. The column counter advances on every clock while its axis is inside. The line counter advances once per line, on the horizontal sync strobe.

The block also produces an overlay enable that goes with the local counters. It is the AND of the two "inside" conditions, delayed by a chain of registers. The chain length matches the latency of the character and glyph memories that read the local counters downstream. The enable can then drive the overlay multiplexer directly.

A small write port sets the four edges, so software can move and resize the window. A parameter selects whether the sync input is taken as a one-clock strobe or reduced to its rising edge first.

Top module: `osd_window_gen`

## Requirements
- R1: While `rst` is high and after it falls, `osd_x`, `osd_y` and `osd_en` are 0. Both axes start outside the window, so the local counters stay at 0 until an opening edge is matched. All four edge registers reset to all ones.
- R2: The column flag is sampled on each clock edge.
  - If `ras_x` equals the left edge, the axis is inside from the next cycle.
  - Otherwise, if `ras_x` equals the right edge, the axis is outside from the next cycle.
  - Otherwise the flag holds.
  - When the left and right edges are equal, the left match wins.
- R3: While the column axis is outside, `osd_x` is 0 after the next edge. While it is inside, `osd_x` increments by one on every clock.
- R4: The line flag follows the same rule with `ras_y`. A match on the top edge enters the window and a match on the bottom edge leaves it. The bottom edge is compared against `ras_y` only: `ras_x` equal to the bottom edge has no effect.
- R5: While the line axis is outside, `osd_y` is 0 after the next edge. While it is inside, `osd_y` increments by one only on a clock where the sync strobe is high. A strobe in the same cycle as the bottom-edge match still counts, and `osd_y` is 0 one cycle later.
- R6: `osd_en` equals "both axes inside" delayed through `EN_DELAY` registers, 4 by default. For a window opened by a left match sampled at edge E, `osd_en` rises after edge E+4 and falls four cycles after the column flag sets.
- R7: Edges are written with `cfg_we` high, `cfg_addr` selecting 0 left, 1 right, 2 top, 3 bottom, and `cfg_data` holding the value. A written value is used by the compare from the clock after the write.
- R8: With `SHAPE_SYNC` = 0, every clock with `hsync` high is a strobe. With `SHAPE_SYNC` = 1, only the first clock of each high run of `hsync` is a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_x | input | CW | Master raster column counter |
| ras_y | input | CW | Master raster line counter |
| hsync | input | 1 | Horizontal sync (strobe or level, see R8) |
| cfg_we | input | 1 | Edge register write enable |
| cfg_addr | input | 2 | Edge register select |
| cfg_data | input | CW | Edge register write data |
| osd_x | output | CW | Column position inside the window |
| osd_y | output | CW | Line position inside the window |
| osd_en | output | 1 | Overlay enable, aligned to the memory pipeline |

## Verification
Two of this block's functions can fall in the same cycle: the line counter's advance on a sync strobe, and the line flag setting on a bottom-edge match. The bench drives `hsync` high in exactly the clock where `ras_y` equals the bottom edge. It expects that strobe to still be counted, and `osd_y` to read 0 on the following clock even though `hsync` stays high. A second collision puts the left and right edges on the same value, and the bench checks that the window opens rather than closes.

// File: rtl/osdw_pkg.sv
package osdw_pkg;

    localparam int OSDW_CW_DEF  = 11;
    localparam int OSDW_NEDGE   = 4;
    localparam int OSDW_NAXIS   = 2;

    typedef enum logic [1:0] {
        EDGE_LEFT   = 2'd0,
        EDGE_RIGHT  = 2'd1,
        EDGE_TOP    = 2'd2,
        EDGE_BOTTOM = 2'd3
    } edge_sel_e;

    typedef enum int {
        AXIS_COL  = 0,
        AXIS_LINE = 1
    } axis_e;

    // Next value of a sticky "outside" flag: an opening match wins over a closing one.
    function automatic logic next_outside(input logic cur, input logic hit_open,
                                          input logic hit_close);
        if (hit_open)
            return 1'b0;
        else if (hit_close)
            return 1'b1;
        else
            return cur;
    endfunction

endpackage

// File: rtl/osdw_cfg_regs.sv
module osdw_cfg_regs
    import osdw_pkg::*;
#(
    parameter int CW = OSDW_CW_DEF
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [1:0]                       addr,
    input  logic [CW-1:0]                    wdata,
    output logic [OSDW_NEDGE-1:0][CW-1:0]    edges
);

    generate
        for (genvar k = 0; k < OSDW_NEDGE; k++) begin : g_edge
            always_ff @(posedge clk) begin
                if (rst)
                    edges[k] <= '1;
                else if (we && (addr == 2'(k)))
                    edges[k] <= wdata;
            end

            a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
                (we && (addr == 2'(k))) |=> (edges[k] == $past(wdata)));
        end
    endgenerate

endmodule

// File: rtl/osdw_axis.sv
module osdw_axis
    import osdw_pkg::*;
#(
    parameter int CW = OSDW_CW_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] edge_open,
    input  logic [CW-1:0] edge_close,
    input  logic          adv,
    output logic          outside,
    output logic [CW-1:0] cnt
);

    logic hit_open;
    logic hit_close;

    assign hit_open  = (pos == edge_open);
    assign hit_close = (pos == edge_close);

    always_ff @(posedge clk) begin
        if (rst)
            outside <= 1'b1;
        else
            outside <= next_outside(outside, hit_open, hit_close);
    end

    always_ff @(posedge clk) begin
        if (rst || outside)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 1'b1;
    end

    // R2 / R4: flag transitions
    a_r2_open_wins: assert property (@(posedge clk) disable iff (rst)
        hit_open |=> !outside);
    a_r2_close_sets: assert property (@(posedge clk) disable iff (rst)
        (hit_close && !hit_open) |=> outside);
    a_r4_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (!hit_open && !hit_close) |=> (outside == $past(outside)));

    // R3 / R5: counter behaviour
    a_r3_zero_outside: assert property (@(posedge clk) disable iff (rst)
        outside |=> (cnt == '0));
    a_r3_step_inside: assert property (@(posedge clk) disable iff (rst)
        (!outside && adv) |=> (cnt == $past(cnt) + 1'b1));
    a_r5_hold_no_adv: assert property (@(posedge clk) disable iff (rst)
        (!outside && !adv) |=> $stable(cnt));

endmodule

// File: rtl/osdw_en_pipe.sv
module osdw_en_pipe #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [DEPTH-1:0] stg;

    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)
                    stg <= '0;
                else
                    stg[0] <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst)
                    stg <= '0;
                else
                    stg <= {stg[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = stg[DEPTH-1];

    // R6: the output never rises unless the head of the chain was already set
    a_r6_no_early_rise: assert property (@(posedge clk) disable iff (rst)
        !(|stg) |=> !dout);

endmodule

// File: rtl/osd_window_gen.sv
module osd_window_gen
    import osdw_pkg::*;
#(
    parameter int CW         = OSDW_CW_DEF,
    parameter int EN_DELAY   = 4,
    parameter bit SHAPE_SYNC = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] ras_x,
    input  logic [CW-1:0] ras_y,
    input  logic          hsync,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [CW-1:0] cfg_data,
    output logic [CW-1:0] osd_x,
    output logic [CW-1:0] osd_y,
    output logic          osd_en
);

    logic [OSDW_NEDGE-1:0][CW-1:0] edges;
    logic                          line_strb;
    logic [CW-1:0]                 ax_pos   [OSDW_NAXIS];
    logic [CW-1:0]                 ax_open  [OSDW_NAXIS];
    logic [CW-1:0]                 ax_close [OSDW_NAXIS];
    logic                          ax_adv   [OSDW_NAXIS];
    logic                          ax_out   [OSDW_NAXIS];
    logic [CW-1:0]                 ax_cnt   [OSDW_NAXIS];
    logic                          both_in;

    osdw_cfg_regs #(.CW(CW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_data),
        .edges (edges)
    );

    // Sync conditioning: pass-through or rising-edge strobe
    generate
        if (SHAPE_SYNC) begin : g_shape
            logic hs_prev;
            always_ff @(posedge clk) begin
                if (rst)
                    hs_prev <= 1'b0;
                else
                    hs_prev <= hsync;
            end
            assign line_strb = hsync && !hs_prev;

            a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
                line_strb |=> !line_strb);
        end else begin : g_pass
            assign line_strb = hsync;
        end
    endgenerate

    assign ax_pos[AXIS_COL]    = ras_x;
    assign ax_open[AXIS_COL]   = edges[EDGE_LEFT];
    assign ax_close[AXIS_COL]  = edges[EDGE_RIGHT];
    assign ax_adv[AXIS_COL]    = 1'b1;
    assign ax_pos[AXIS_LINE]   = ras_y;
    assign ax_open[AXIS_LINE]  = edges[EDGE_TOP];
    assign ax_close[AXIS_LINE] = edges[EDGE_BOTTOM];
    assign ax_adv[AXIS_LINE]   = line_strb;

    generate
        for (genvar a = 0; a < OSDW_NAXIS; a++) begin : g_axis
            osdw_axis #(.CW(CW)) u_axis (
                .clk        (clk),
                .rst        (rst),
                .pos        (ax_pos[a]),
                .edge_open  (ax_open[a]),
                .edge_close (ax_close[a]),
                .adv        (ax_adv[a]),
                .outside    (ax_out[a]),
                .cnt        (ax_cnt[a])
            );
        end
    endgenerate

    assign both_in = !ax_out[AXIS_COL] && !ax_out[AXIS_LINE];

    osdw_en_pipe #(.DEPTH(EN_DELAY)) u_en (
        .clk  (clk),
        .rst  (rst),
        .din  (both_in),
        .dout (osd_en)
    );

    assign osd_x = ax_cnt[AXIS_COL];
    assign osd_y = ax_cnt[AXIS_LINE];

    // R4: a line counter is zero whenever the line axis was outside
    a_r4_line_zero: assert property (@(posedge clk) disable iff (rst)
        ax_out[AXIS_LINE] |=> (osd_y == '0));

endmodule

// File: tb/osd_window_gen_test.sv
module osd_window_gen_test;

    localparam int CW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] ras_x = '0;
    logic [CW-1:0] ras_y = '0;
    logic          hsync = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [CW-1:0] cfg_data = '0;
    logic [CW-1:0] osd_x, osd_y, shp_x, shp_y;
    logic          osd_en, shp_en;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    osd_window_gen #(.CW(CW), .EN_DELAY(4), .SHAPE_SYNC(1'b0)) uut (
        .clk(clk), .rst(rst), .ras_x(ras_x), .ras_y(ras_y), .hsync(hsync),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .osd_x(osd_x), .osd_y(osd_y), .osd_en(osd_en)
    );

    osd_window_gen #(.CW(CW), .EN_DELAY(4), .SHAPE_SYNC(1'b1)) uut_shp (
        .clk(clk), .rst(rst), .ras_x(ras_x), .ras_y(ras_y), .hsync(hsync),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .osd_x(shp_x), .osd_y(shp_y), .osd_en(shp_en)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one pixel at the falling edge; return 2 ns after the rising edge.
    task automatic tick(input int x, input int y, input bit hs);
        @(negedge clk);
        ras_x = CW'(x);
        ras_y = CW'(y);
        hsync = hs;
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = 2'(a);
        cfg_data = CW'(d);
        @(posedge clk);
        #2;
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "osd_x in reset", int'(osd_x), 0);
        chk("R1", "osd_y in reset", int'(osd_y), 0);
        chk("R1", "osd_en in reset", int'(osd_en), 0);
        @(negedge clk);
        rst = 1'b0;
        tick(3, 3, 1'b1);
        tick(4, 3, 1'b0);
        chk("R1", "osd_x after reset", int'(osd_x), 0);
        chk("R1", "osd_y after reset", int'(osd_y), 0);
        chk("R1", "osd_en after reset", int'(osd_en), 0);
    endtask

    task automatic t_config();
        wr(0, 5);   // left
        wr(1, 10);  // right
        wr(2, 2);   // top
        wr(3, 4);   // bottom
    endtask

    // R3: column run with the line axis outside
    task automatic t_col_run();
        for (int k = 0; k < 16; k++) begin
            tick(k, 0, 1'b0);
            chk("R3", $sformatf("osd_x at col %0d", k), int'(osd_x),
                (k >= 6 && k <= 10) ? k - 5 : 0);
            chk("R6", $sformatf("osd_en line outside col %0d", k), int'(osd_en), 0);
            chk("R5", "osd_y stays zero", int'(osd_y), 0);
        end
    endtask

    // R6: both axes inside, enable delayed by four registers
    task automatic t_enable();
        tick(0, 2, 1'b0);
        for (int k = 0; k < 16; k++) begin
            tick(k, 2, 1'b0);
            chk("R2", $sformatf("osd_x in window col %0d", k), int'(osd_x),
                (k >= 6 && k <= 10) ? k - 5 : 0);
            chk("R6", $sformatf("osd_en col %0d", k), int'(osd_en),
                (k >= 9 && k <= 13) ? 1 : 0);
        end
    endtask

    // R5, R8 and the strobe / bottom-edge collision
    task automatic t_lines();
        tick(0, 3, 1'b1);
        chk("R5", "osd_y first strobe", int'(osd_y), 1);
        tick(1, 3, 1'b0);
        chk("R5", "osd_y no strobe", int'(osd_y), 1);
        tick(2, 3, 1'b1);
        chk("R5", "osd_y second strobe", int'(osd_y), 2);
        tick(3, 3, 1'b1);
        chk("R8", "unshaped counts level", int'(osd_y), 3);
        chk("R8", "shaped counts edge once", int'(shp_y), 2);
        tick(0, 3, 1'b0);
        tick(0, 4, 1'b1);
        chk("R5", "strobe with bottom match counts", int'(osd_y), 4);
        chk("R8", "shaped strobe with bottom match", int'(shp_y), 3);
        tick(0, 5, 1'b1);
        chk("R5", "osd_y zero after bottom", int'(osd_y), 0);
        tick(0, 5, 1'b1);
        chk("R5", "osd_y held zero outside", int'(osd_y), 0);
    endtask

    // R4: bottom compares against the line counter only
    task automatic t_bottom_axis();
        tick(0, 2, 1'b0);
        tick(4, 0, 1'b1);
        tick(4, 0, 1'b1);
        chk("R4", "column equal to bottom ignored", int'(osd_y), 2);
    endtask

    // R2 equal edges, R7 write timing
    task automatic t_edges();
        wr(0, 7);
        wr(1, 7);
        tick(7, 0, 1'b0);
        chk("R2", "equal edges: flag opens", int'(osd_x), 0);
        tick(8, 0, 1'b0);
        chk("R2", "equal edges: counting", int'(osd_x), 1);
        tick(9, 0, 1'b0);
        chk("R2", "equal edges: counting 2", int'(osd_x), 2);
        wr(1, 12);
        chk("R7", "count during write", int'(osd_x), 3);
        tick(12, 0, 1'b0);
        chk("R7", "new right edge seen", int'(osd_x), 4);
        tick(13, 0, 1'b0);
        chk("R7", "closed by new right edge", int'(osd_x), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        t_config();
        t_col_run();
        t_enable();
        t_lines();
        t_bottom_axis();
        t_edges();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule